// File: doc/BRIEF.md
# Interrupt Acceptance and Priority-Level Sequencer

This block sits beside a processor's instruction sequencer. It takes one pending interrupt request and accepts it only at an instruction boundary, which is the cycle in which `insn_done` is high. On acceptance it updates the processor's interrupt priority level register. The new level depends on the source class. A maskable request loads its own level. A critical source (NMI, watchdog or oscillator-fail) forces the highest level. Every other class leaves the level unchanged. The block then models the interrupt entry sequence as a down-counter and raises a one-cycle `done` strobe on the last cycle of that sequence.

The sequence length has two cases. On the 16-bit bus it is a base length plus one cycle for an odd vector address and one cycle for an odd stack pointer. On the 8-bit bus it is a fixed base length. In both cases the debug class adds two cycles, and the address-hit and single-step classes add one cycle each. Arbitration among several requests, the vector memory and the register push belong to other blocks.

The control is a three-state machine:
- IDLE waits for a request.
- HOLD keeps a request that arrived before the instruction boundary.
- RUN counts the entry sequence.

Its transitions are:
- IDLE→RUN: a request arrives together with a boundary.
- IDLE→HOLD: a request arrives without a boundary.
- HOLD→RUN: the boundary arrives.
- RUN→IDLE: the final count is reached.
- Any state→IDLE: synchronous reset.

Top module: `irq_accept_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `ipl` to 0, `busy` to 0 and `done` to 0 on the next clock. This also holds in the middle of a sequence.
- R2: A request is accepted only at a clock edge where `insn_done` is 1. A request seen without a boundary is held with `busy` low. Its class and level are captured at that edge, and later changes to `req_class`, `req_level` or `req_valid` are ignored until acceptance.
- R3: Class code 0 (maskable) loads `ipl` with the request's level at the acceptance edge.
- R4: Class code 1 (critical) sets `ipl` to all ones (7 for a 3-bit level).
- R5: Class codes 2 (software), 3 (address hit), 4 (debug) and 5 (single step), and the unused codes 6 and 7, leave `ipl` unchanged.
- R6: With `bus_narrow`=0 the sequence lasts 18 + `vec_b0` + `sp_b0` cycles before any class extra.
- R7: With `bus_narrow`=1 the sequence lasts 20 cycles before any class extra, whatever the parities.
- R8: Class 4 adds 2 cycles and classes 3 and 5 add 1 cycle, on either bus width.
- R9: `busy` is high for exactly the sequence length L, starting in the cycle after the acceptance edge. `done` is high only in the last of those cycles.
- R10: Requests presented while `busy` is high are ignored. They change neither `ipl` nor the length of the running sequence.
- R11: Bus width and both parity bits are sampled at the acceptance edge. Changes to them during the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An interrupt request is pending |
| req_class | input | 3 | Source class code |
| req_level | input | IPL_W | Priority level of a maskable request |
| insn_done | input | 1 | The current instruction completes this cycle |
| bus_narrow | input | 1 | 1 selects the 8-bit bus, 0 selects the 16-bit bus |
| vec_b0 | input | 1 | Bit 0 of the vector address |
| sp_b0 | input | 1 | Bit 0 of the stack pointer |
| ipl | output | IPL_W | Current interrupt priority level |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle strobe on the last sequence cycle |

## Verification
The assertions assume that the environment drives `rst` high on the first clock edge. They also assume the default base lengths, so that every sequence lasts between the shortest base length and the longest base length plus two. The bench applies reset from time zero and does not override the parameters. It sweeps every class code, both bus widths, both parities and both boundary timings. While a sequence runs, the bench keeps driving a critical request with inverted bus and parity inputs, so that ignored stimulus actually reaches the inputs. It releases that request in the cycle where `done` is high, so that no new request is accepted at the edge that returns the machine to IDLE.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Source class codes; codes 6 and 7 are unused and behave like software.
    typedef enum logic [2:0] {
        CLS_MASKABLE = 3'd0,
        CLS_CRITICAL = 3'd1,
        CLS_SOFT     = 3'd2,
        CLS_ADDR_HIT = 3'd3,
        CLS_DEBUG    = 3'd4,
        CLS_STEP     = 3'd5
    } irq_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/irq_seq_len.sv
module irq_seq_len
    import irq_seq_pkg::*;
#(
    parameter int BASE_WIDE   = 18,
    parameter int BASE_NARROW = 20,
    parameter int LEN_W       = 5
) (
    input  logic [2:0]       cls,
    input  logic             narrow,
    input  logic             vec_odd,
    input  logic             sp_odd,
    output logic [LEN_W-1:0] len
);

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] extra;

    always_comb begin
        if (narrow) begin
            base = LEN_W'(BASE_NARROW);
        end else begin
            base = LEN_W'(BASE_WIDE) + LEN_W'(vec_odd) + LEN_W'(sp_odd);
        end

        unique case (cls)
            CLS_DEBUG:              extra = LEN_W'(2);
            CLS_ADDR_HIT, CLS_STEP: extra = LEN_W'(1);
            default:                extra = '0;
        endcase

        len = base + extra;
    end

endmodule

// File: rtl/irq_ipl_next.sv
module irq_ipl_next
    import irq_seq_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic [2:0]       cls,
    input  logic [IPL_W-1:0] req_level,
    input  logic [IPL_W-1:0] cur_ipl,
    output logic [IPL_W-1:0] nxt_ipl
);

    always_comb begin
        unique case (cls)
            CLS_MASKABLE: nxt_ipl = req_level;
            CLS_CRITICAL: nxt_ipl = '1;
            default:      nxt_ipl = cur_ipl;
        endcase
    end

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int IPL_W       = 3,
    parameter int BASE_WIDE   = 18,
    parameter int BASE_NARROW = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_class,
    input  logic [IPL_W-1:0] req_level,
    input  logic             insn_done,
    input  logic             bus_narrow,
    input  logic             vec_b0,
    input  logic             sp_b0,
    output logic [IPL_W-1:0] ipl,
    output logic             busy,
    output logic             done
);

    localparam int WIDE_MAX = BASE_WIDE + 2;
    localparam int LEN_MAX  = ((WIDE_MAX > BASE_NARROW) ? WIDE_MAX : BASE_NARROW) + 2;
    localparam int LEN_MIN  = (BASE_WIDE < BASE_NARROW) ? BASE_WIDE : BASE_NARROW;
    localparam int LEN_W    = $clog2(LEN_MAX + 1);

    seq_state_e       state_q, state_d;
    logic [IPL_W-1:0] ipl_q;
    logic [IPL_W-1:0] held_lvl_q;
    logic [2:0]       held_cls_q;
    logic [LEN_W-1:0] cnt_q;

    logic             accept;
    logic [2:0]       acc_cls;
    logic [IPL_W-1:0] acc_lvl;
    logic [IPL_W-1:0] ipl_nxt;
    logic [LEN_W-1:0] seq_len;

    // Next-state and acceptance decision
    always_comb begin
        accept  = 1'b0;
        acc_cls = req_class;
        acc_lvl = req_level;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (insn_done) begin
                        accept  = 1'b1;
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                acc_cls = held_cls_q;
                acc_lvl = held_lvl_q;
                if (insn_done) begin
                    accept  = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    irq_seq_len #(
        .BASE_WIDE  (BASE_WIDE),
        .BASE_NARROW(BASE_NARROW),
        .LEN_W      (LEN_W)
    ) u_len (
        .cls    (acc_cls),
        .narrow (bus_narrow),
        .vec_odd(vec_b0),
        .sp_odd (sp_b0),
        .len    (seq_len)
    );

    irq_ipl_next #(
        .IPL_W(IPL_W)
    ) u_ipl (
        .cls      (acc_cls),
        .req_level(acc_lvl),
        .cur_ipl  (ipl_q),
        .nxt_ipl  (ipl_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Level, held request and sequence counter
    always_ff @(posedge clk) begin
        if (rst) begin
            ipl_q      <= '0;
            held_lvl_q <= '0;
            held_cls_q <= '0;
            cnt_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid && !insn_done) begin
                held_cls_q <= req_class;
                held_lvl_q <= req_level;
            end
            if (accept) begin
                ipl_q <= ipl_nxt;
                cnt_q <= seq_len - LEN_W'(1);
            end else if (state_q == ST_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        ipl  = ipl_q;
        busy = (state_q == ST_RUN);
        done = (state_q == ST_RUN) && (cnt_q == '0);
    end

    // Checker state: cycles spent busy so far
    logic [LEN_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + LEN_W'(1);
        else           run_cnt <= '0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ipl == '0 && !busy && !done));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10
    ipl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ipl));

    // R10
    no_early_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R4
    crit_level_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && acc_cls == CLS_CRITICAL) |=> (ipl == '1 && busy));

    // R6
    seq_len_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt >= LEN_W'(LEN_MIN - 1) && run_cnt <= LEN_W'(LEN_MAX - 1)));

endmodule

// File: tb/irq_accept_seq_tb.sv
`timescale 1ns/1ps
module irq_accept_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic [2:0] req_level = 3'd0;
    logic       insn_done = 1'b0;
    logic       bus_narrow = 1'b0;
    logic       vec_b0 = 1'b0;
    logic       sp_b0 = 1'b0;
    logic [2:0] ipl;
    logic       busy;
    logic       done;

    int total = 0;
    int bad   = 0;
    logic [2:0] exp_ipl = 3'd0;

    always #10 clk = ~clk;

    irq_accept_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_class (req_class),
        .req_level (req_level),
        .insn_done (insn_done),
        .bus_narrow(bus_narrow),
        .vec_b0    (vec_b0),
        .sp_b0     (sp_b0),
        .ipl       (ipl),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run_one(input int cls, input int lvl, input int nar,
                           input int vp, input int sp, input int w);
        int         len;
        logic [2:0] e;
        string      ltag;
        len  = (nar != 0) ? 20 : 18 + vp + sp;
        ltag = (nar != 0) ? "R7 R11" : "R6 R11";
        if (cls == 4) begin
            len += 2;
            ltag = "R8";
        end
        if (cls == 3 || cls == 5) begin
            len += 1;
            ltag = "R8";
        end
        if (cls == 0)      e = 3'(lvl);
        else if (cls == 1) e = 3'd7;
        else               e = exp_ipl;

        @(negedge clk);
        req_valid  = 1'b1;
        req_class  = 3'(cls);
        req_level  = 3'(lvl);
        bus_narrow = nar[0];
        vec_b0     = vp[0];
        sp_b0      = sp[0];
        insn_done  = (w == 0);
        for (int i = 1; i <= w; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R2 hold not busy", busy, 0);
            chk(ipl == exp_ipl, "R2 hold keeps level", ipl, exp_ipl);
            req_valid = 1'b0;
            req_class = ~3'(cls);
            req_level = ~3'(lvl);
            insn_done = (i == w);
        end

        @(negedge clk);
        if (cls == 0)      chk(ipl == e, "R3 R2", ipl, e);
        else if (cls == 1) chk(ipl == e, "R4", ipl, e);
        else               chk(ipl == e, "R5", ipl, e);
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        // Noise during the sequence
        req_valid  = 1'b1;
        insn_done  = 1'b1;
        req_class  = 3'd1;
        req_level  = 3'd0;
        bus_narrow = ~nar[0];
        vec_b0     = ~vp[0];
        sp_b0      = ~sp[0];
        for (int k = 1; k <= len; k++) begin
            if (k > 1) @(negedge clk);
            chk(busy == 1'b1, "R9 busy span", k, len);
            chk(done == (k == len), ltag, k, len);
            if (k == len) begin
                req_valid = 1'b0;
                insn_done = 1'b0;
            end
        end
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy drops", busy, 0);
        chk(done == 1'b0, "R9 done single", done, 0);
        chk(ipl == e, "R10 ignored while busy", ipl, e);
        exp_ipl = e;
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ipl == 3'd0, "R1 ipl", ipl, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        rst = 1'b0;

        for (int cls = 0; cls < 8; cls++)
            for (int nar = 0; nar < 2; nar++)
                for (int vp = 0; vp < 2; vp++)
                    for (int sp = 0; sp < 2; sp++)
                        for (int w = 0; w <= 2; w += 2)
                            run_one(cls, (cls + 2*nar + vp + 3*sp + w) % 8, nar, vp, sp, w);

        // Reset in the middle of a sequence
        run_one(0, 5, 0, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b1;
        insn_done = 1'b1;
        req_class = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        insn_done = 1'b0;
        chk(busy == 1'b1 && ipl == 3'd7, "R4 before reset", ipl, 7);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(ipl == 3'd0, "R1 mid-run ipl", ipl, 0);
        chk(busy == 1'b0, "R1 mid-run busy", busy, 0);
        rst = 1'b0;
        exp_ipl = 3'd0;
        run_one(2, 0, 1, 1, 1, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule